// File: doc/BRIEF.md
# Nested Hardware Loop Sequencer

This block sits next to an instruction fetch unit's program counter and runs counted loops without any branch instruction in the loop body. Software describes each loop with three configuration writes (the address of the last instruction of the body, the address to return to, and the number of passes) and then a fourth write that arms the loop. Up to `DEPTH` loops can be armed at once, always from the outermost to the innermost. All of this setup runs once, before the outermost loop is entered. No setup code runs inside the loops.

Once armed, the sequencer compares every fetched address against the end addresses of the armed loops. A loop may reach its end with passes still to go. The sequencer then overrides the next fetch address with that loop's return address in the same cycle, so a taken loop-back costs no cycles. It also counts the pass down and restores every loop nested inside to its initial count. An inner loop that has run out stays armed, and it is filled again the next time an enclosing loop goes round. When the outermost loop finishes, every armed loop is dropped and the sequencer is empty again.

Top module: `zol_loop_ctrl`

## Requirements
- R1: A configuration write with `cfg_op` 0 stages an end address, 1 stages a return address, 2 stages a pass count (low `CW` bits of `cfg_data`), and 3 arms a loop from the staged values into the next free slot. Arming never produces a redirect: fetch carries on sequentially until an end address is reached.
- R2: When `fetch_valid` is high and `fetch_pc` equals the end address of an armed loop that has more than one pass left, `redirect` is high in that same cycle and `redirect_pc` carries that loop's return address.
- R3: At most `DEPTH` (4) loops are armed at once. An arm request while all slots are full changes no loop state. It sets `arm_overflow`, which stays high until reset.
- R4: A loop armed with count N executes its body N times per activation, so it takes N-1 loop-backs. Counts 0 and 1 give a single pass with no loop-back.
- R5: When several armed loops share the end address being fetched, the innermost one with passes left takes the loop-back. Inner loops with no passes left fall through to the next outer loop.
- R6: Every taken loop-back of a loop restores each loop armed inside it to its initial pass count.
- R7: When the outermost armed loop reaches its end address with no passes left, all armed loops are removed. Their end addresses no longer redirect, and the next arm fills the first slot.
- R8: An inner loop that reaches its end with no passes left gives no redirect and stays armed, waiting for a reload from an enclosing loop.
- R9: After reset no loop is armed, `redirect` is low and `arm_overflow` is low.
- R10: While `fetch_valid` is low there is no redirect, and no loop count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | Command: 0 end, 1 return, 2 count, 3 arm |
| cfg_data | input | AW | Address or count for the command |
| fetch_valid | input | 1 | The fetch address is consumed this cycle |
| fetch_pc | input | AW | Address being fetched |
| redirect | output | 1 | Override the sequential next fetch address |
| redirect_pc | output | AW | Next fetch address when `redirect` is high |
| arm_overflow | output | 1 | Sticky: an arm request found all slots full |

## Verification
Assertions check the structural invariants on every cycle: the armed slots form a contiguous stack whose size matches the depth counter, the overflow flag is sticky, a full stack ignores an arm, a loop-back only happens on a valid fetch, a count is only decremented while passes remain, and a reload restores the initial count. Other behaviours only show up over a whole program run, and only the bench scenarios can show them. These are the product of nested pass counts, the innermost-first choice at a shared end address, the single pass for counts 0 and 1, and the silence of end addresses once the outermost loop retires. The bench walks a program counter through loop bodies and checks every cycle against a behavioural model. It also counts how often each address is fetched.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic [1:0] {
    OP_SET_END = 2'd0,
    OP_SET_RET = 2'd1,
    OP_SET_CNT = 2'd2,
    OP_ARM     = 2'd3
  } zol_op_e;
endpackage

// File: rtl/zol_cfg_stage.sv
module zol_cfg_stage
  import zol_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_valid,
  input  logic [1:0]    cfg_op,
  input  logic [AW-1:0] cfg_data,
  output logic [AW-1:0] stg_end,
  output logic [AW-1:0] stg_ret,
  output logic [CW-1:0] stg_cnt,
  output logic          arm_req
);
  zol_op_e op;
  assign op      = zol_op_e'(cfg_op);
  assign arm_req = cfg_valid && (op == OP_ARM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_end <= '0;
      stg_ret <= '0;
      stg_cnt <= '0;
    end else if (cfg_valid) begin
      case (op)
        OP_SET_END: stg_end <= cfg_data;
        OP_SET_RET: stg_ret <= cfg_data;
        OP_SET_CNT: stg_cnt <= cfg_data[CW-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/zol_slot.sv
module zol_slot #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_end,
  input  logic [AW-1:0] ld_ret,
  input  logic [CW-1:0] ld_cnt,
  input  logic          clear,
  input  logic          dec,
  input  logic          reload,
  input  logic [AW-1:0] pc,
  output logic          valid,
  output logic          match,
  output logic          live,
  output logic [AW-1:0] ret_addr
);
  logic [AW-1:0] end_q;
  logic [CW-1:0] init_q;
  logic [CW-1:0] rem_q;

  // a pass remains beyond the current one
  function automatic logic may_repeat(input logic [CW-1:0] rem);
    return rem > CW'(1);
  endfunction

  function automatic logic [CW-1:0] after_pass(input logic [CW-1:0] rem);
    return rem - CW'(1);
  endfunction

  assign match = valid && (end_q == pc);
  assign live  = may_repeat(rem_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      end_q    <= '0;
      ret_addr <= '0;
      init_q   <= '0;
      rem_q    <= '0;
    end else if (load) begin
      valid    <= 1'b1;
      end_q    <= ld_end;
      ret_addr <= ld_ret;
      init_q   <= ld_cnt;
      rem_q    <= ld_cnt;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (dec && valid) begin
      rem_q <= after_pass(rem_q);
    end else if (reload && valid) begin
      rem_q <= init_q;
    end
  end

  // R4: a loop-back is only granted while passes remain
  assert_dec_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (valid && rem_q > CW'(1)));
  // R6: a reload restores the initial count
  assert_reload_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && valid && !load && !clear && !dec) |=> (rem_q == $past(init_q)));
endmodule

// File: rtl/zol_pick.sv
module zol_pick #(
  parameter int DEPTH = 4
) (
  input  logic             fetch_valid,
  input  logic [DEPTH-1:0] match,
  input  logic [DEPTH-1:0] live,
  output logic [DEPTH-1:0] hit_mask,
  output logic [DEPTH-1:0] reload_mask,
  output logic             hit,
  output logic             outer_done
);
  // innermost (highest slot) matching loop with passes left wins
  always_comb begin
    hit_mask = '0;
    hit      = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!hit && fetch_valid && match[i] && live[i]) begin
        hit_mask[i] = 1'b1;
        hit         = 1'b1;
      end
    end
  end

  // every slot above the winner is nested inside it
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      reload_mask[i] = seen;
      seen = seen | hit_mask[i];
    end
  end

  assign outer_done = fetch_valid && match[0] && !hit;
endmodule

// File: rtl/zol_loop_ctrl.sv
module zol_loop_ctrl #(
  parameter int AW    = 16,
  parameter int CW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_valid,
  input  logic [1:0]    cfg_op,
  input  logic [AW-1:0] cfg_data,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  output logic          redirect,
  output logic [AW-1:0] redirect_pc,
  output logic          arm_overflow
);
  localparam int DW = $clog2(DEPTH + 1);

  logic [AW-1:0]    stg_end, stg_ret;
  logic [CW-1:0]    stg_cnt;
  logic             arm_req;
  logic [DW-1:0]    depth;
  logic [DW-1:0]    base;
  logic             arm_ok, arm_full;
  logic [DEPTH-1:0] load_mask, valid, match, live, hit_mask, reload_mask;
  logic [AW-1:0]    ret_addr [DEPTH];
  logic             hit, outer_done;

  zol_cfg_stage #(.AW(AW), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
    .cfg_data(cfg_data), .stg_end(stg_end), .stg_ret(stg_ret),
    .stg_cnt(stg_cnt), .arm_req(arm_req)
  );

  // a retiring outer loop empties the stack before a same-cycle arm lands
  assign base     = outer_done ? '0 : depth;
  assign arm_full = arm_req && (base == DW'(DEPTH));
  assign arm_ok   = arm_req && !arm_full;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign load_mask[g] = arm_ok && (base == DW'(g));
      zol_slot #(.AW(AW), .CW(CW)) u_slot (
        .clk(clk), .rst_n(rst_n), .load(load_mask[g]),
        .ld_end(stg_end), .ld_ret(stg_ret), .ld_cnt(stg_cnt),
        .clear(outer_done), .dec(hit_mask[g]), .reload(reload_mask[g]),
        .pc(fetch_pc), .valid(valid[g]), .match(match[g]),
        .live(live[g]), .ret_addr(ret_addr[g])
      );
    end
  endgenerate

  zol_pick #(.DEPTH(DEPTH)) u_pick (
    .fetch_valid(fetch_valid), .match(match), .live(live),
    .hit_mask(hit_mask), .reload_mask(reload_mask),
    .hit(hit), .outer_done(outer_done)
  );

  always_comb begin
    redirect_pc = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_mask[i]) redirect_pc = redirect_pc | ret_addr[i];
    end
  end
  assign redirect = hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth        <= '0;
      arm_overflow <= 1'b0;
    end else begin
      if (arm_ok)        depth <= base + DW'(1);
      else if (outer_done) depth <= '0;
      if (arm_full)      arm_overflow <= 1'b1;
    end
  end

  // R3: slots in use form a contiguous stack matching the depth counter
  assert_stack_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (depth <= DW'(DEPTH)) && ($countones(valid) == int'(depth)) &&
    ((({1'b0, valid} + 1'b1) & {1'b0, valid}) == '0));
  // R3: overflow flag is sticky
  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_overflow |=> arm_overflow);
  // R3: an arm into a full stack leaves the depth unchanged
  assert_full_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && !outer_done && depth == DW'(DEPTH)) |=> (depth == DW'(DEPTH)));
  // R10: no loop-back without a valid fetch
  assert_redirect_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> fetch_valid);
  // R7: retiring the outer loop empties the stack
  assert_retire_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (outer_done && !arm_req) |=> (depth == '0));
endmodule

// File: tb/zol_loop_ctrl_test.sv
module zol_loop_ctrl_test;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0;
  logic [1:0] cfg_op = '0;
  logic [AW-1:0] cfg_data = '0;
  logic fetch_valid = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic redirect;
  logic [AW-1:0] redirect_pc;
  logic arm_overflow;

  zol_loop_ctrl #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
    .cfg_data(cfg_data), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .redirect(redirect), .redirect_pc(redirect_pc), .arm_overflow(arm_overflow)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cycles = 0;

  // behavioural model
  int m_end[DEPTH], m_ret[DEPTH], m_init[DEPTH], m_rem[DEPTH];
  int m_depth, m_err, s_end, s_ret, s_cnt;
  int exp_hit;
  int visits[256];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_depth = 0; m_err = 0; s_end = 0; s_ret = 0; s_cnt = 0;
    for (int i = 0; i < DEPTH; i++) begin
      m_end[i] = 0; m_ret[i] = 0; m_init[i] = 0; m_rem[i] = 0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_valid = 1'b0; fetch_valid = 1'b0;
    repeat (2) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // compare at mid-cycle, then advance the model at the clock edge
  task automatic tick();
    bit retire;
    #1;
    exp_hit = -1;
    if (fetch_valid) begin
      for (int i = m_depth - 1; i >= 0; i--) begin
        if (exp_hit < 0 && m_end[i] == int'(fetch_pc) && m_rem[i] > 1) exp_hit = i;
      end
    end
    chk(redirect == (exp_hit >= 0), "R2 redirect", int'(redirect), int'(exp_hit >= 0));
    if (exp_hit >= 0)
      chk(int'(redirect_pc) == m_ret[exp_hit], "R2 redirect_pc", int'(redirect_pc), m_ret[exp_hit]);
    chk(int'(arm_overflow) == m_err, "R3 overflow flag", int'(arm_overflow), m_err);
    @(posedge clk);
    retire = fetch_valid && exp_hit < 0 && m_depth > 0 && m_end[0] == int'(fetch_pc);
    if (exp_hit >= 0) begin
      m_rem[exp_hit]--;
      for (int j = exp_hit + 1; j < m_depth; j++) m_rem[j] = m_init[j];
    end
    if (retire) m_depth = 0;
    if (cfg_valid) begin
      case (cfg_op)
        2'd0: s_end = int'(cfg_data);
        2'd1: s_ret = int'(cfg_data);
        2'd2: s_cnt = int'(cfg_data) % 256;
        default: begin
          if (m_depth == DEPTH) m_err = 1;
          else begin
            m_end[m_depth] = s_end; m_ret[m_depth] = s_ret;
            m_init[m_depth] = s_cnt; m_rem[m_depth] = s_cnt;
            m_depth++;
          end
        end
      endcase
    end
    @(negedge clk);
  endtask

  task automatic cfg(input int op, input int data);
    cfg_valid = 1'b1; cfg_op = 2'(op); cfg_data = AW'(data);
    tick();
    cfg_valid = 1'b0;
  endtask

  task automatic arm_loop(input int e, input int r, input int n);
    cfg(0, e); cfg(1, r); cfg(2, n); cfg(3, 0);
  endtask

  task automatic walk(input int start, input int stop);
    int pc;
    int guard;
    pc = start; guard = 0;
    for (int i = 0; i < 256; i++) visits[i] = 0;
    while (pc <= stop && guard < 5000) begin
      fetch_valid = 1'b1; fetch_pc = AW'(pc);
      tick();
      visits[pc]++;
      pc = (exp_hit >= 0) ? m_ret[exp_hit] : pc + 1;
      guard++;
    end
    fetch_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        done = 1;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R9: reset state
    #1;
    chk(redirect == 1'b0, "R9 redirect after reset", int'(redirect), 0);
    chk(arm_overflow == 1'b0, "R9 overflow after reset", int'(arm_overflow), 0);
    @(negedge clk);

    // R1: arm while fetching the return address gives no jump
    fetch_valid = 1'b1; fetch_pc = 16'd10;
    cfg(0, 12); cfg(1, 10); cfg(2, 3);
    cfg_valid = 1'b1; cfg_op = 2'd3; #1;
    chk(redirect == 1'b0, "R1 arm causes no jump", int'(redirect), 0);
    tick();
    cfg_valid = 1'b0; fetch_valid = 1'b0;
    // R4: three passes
    walk(8, 14);
    chk(visits[11] == 3, "R4 count 3 passes", visits[11], 3);
    // R7: loop retired, end address silent
    walk(8, 14);
    chk(visits[11] == 1, "R7 retired loop silent", visits[11], 1);

    // R4: counts 1 and 0 give a single pass
    arm_loop(12, 10, 1);
    walk(8, 14);
    chk(visits[11] == 1, "R4 count 1 single pass", visits[11], 1);
    arm_loop(12, 10, 0);
    walk(8, 14);
    chk(visits[11] == 1, "R4 count 0 single pass", visits[11], 1);

    // R6 R8: three nested loops, declared outer first
    arm_loop(50, 30, 3);
    arm_loop(45, 32, 2);
    arm_loop(40, 34, 4);
    walk(28, 52);
    chk(visits[35] == 24, "R6 innermost body", visits[35], 24);
    chk(visits[33] == 6, "R8 middle body", visits[33], 6);
    chk(visits[31] == 3, "R6 outer body", visits[31], 3);
    walk(28, 52);
    chk(visits[35] == 1, "R7 nest retired", visits[35], 1);

    // R5: shared end address, innermost first
    arm_loop(70, 60, 2);
    arm_loop(70, 65, 3);
    walk(58, 72);
    chk(visits[66] == 6, "R5 inner body shared end", visits[66], 6);
    chk(visits[61] == 2, "R5 outer body shared end", visits[61], 2);

    // R10: no fetch strobe, no redirect and no count change
    arm_loop(12, 10, 2);
    fetch_valid = 1'b0; fetch_pc = 16'd12; #1;
    chk(redirect == 1'b0, "R10 no redirect without fetch", int'(redirect), 0);
    tick();
    walk(8, 14);
    chk(visits[11] == 2, "R10 count untouched", visits[11], 2);

    // R3: fifth arm ignored and flagged
    arm_loop(250, 240, 2);
    arm_loop(249, 241, 2);
    arm_loop(248, 242, 2);
    arm_loop(247, 243, 2);
    #1;
    chk(arm_overflow == 1'b0, "R3 four loops fit", int'(arm_overflow), 0);
    @(negedge clk);
    arm_loop(90, 85, 3);
    #1;
    chk(arm_overflow == 1'b1, "R3 fifth arm flagged", int'(arm_overflow), 1);
    @(negedge clk);
    walk(84, 92);
    chk(visits[86] == 1, "R3 fifth loop ignored", visits[86], 1);
    #1;
    chk(arm_overflow == 1'b1, "R3 flag sticky", int'(arm_overflow), 1);
    @(negedge clk);

    do_reset();
    #1;
    chk(arm_overflow == 1'b0, "R9 reset clears flag", int'(arm_overflow), 0);
    @(negedge clk);
    walk(245, 251);
    chk(visits[241] == 0 && visits[246] == 1, "R9 no loops after reset", visits[246], 1);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule